// File: doc/BRIEF.md
# Programmable Flag Pin Controller

This block manages a bank of general-purpose flag pins behind a small register bus. Software picks the direction of each pin and drives the output pins through write-one-to-set and write-one-to-clear ports. It reads back the live pin levels and configures each pin as an interrupt source. The chip pads take `pin_out` and use `pin_oe` as their output enable. `pins_in` comes back from the pads and passes through a two-flop synchronizer before any logic uses it.

Each pin has its own polarity and its own sensitivity. In level mode the request follows the active level and is never stored. In edge mode the detector watches either the inactive-to-active transition alone or every transition, and the event is held in a sticky pending bit until software writes a 1 to clear it. An input pin is a hardware interrupt source. An output pin is a software interrupt source, because its trigger is the value software drives. The block gives one registered request per pin and one combined request.

Top module: `flag_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_oe`, `pin_out`, `pin_irq`, `irq_any` and `rdata` are all zero. All pins are inputs, all enables are off, polarity is active high (0), sensitivity is level (0), and no pending bit is set.
- R2: Address 0 holds the direction mask (1 = output). `pin_oe` equals that mask, and a write shows on `pin_oe` one cycle after the write cycle. With no write to address 0, `pin_oe` does not change.
- R3: A write to address 1 sets each output latch bit whose `wdata` bit is 1. A write to address 2 clears each bit whose `wdata` bit is 1. Bits written as 0 keep their value. A write to address 9 loads the whole latch. `pin_out` shows the latch one cycle after the write.
- R4: A read with `rd_en` at address 1 or 2 returns each pin's source one cycle later. The source is the latched output for an output pin, and for an input pin it is `pins_in` delayed by two register stages. Reading addresses 0, 3, 4, 5, 6, 7, 8 and 9 returns direction, mask, mask, polarity, sensitivity, edge mode, pending and the output latch. Any other address reads 0, and `rdata` holds its value when `rd_en` is low.
- R5: A write to address 3 sets interrupt enable bits where `wdata` is 1, and a write to address 4 clears them. `pin_irq` is never high for a pin whose enable was low in the previous cycle.
- R6: For a pin with sensitivity 0 (level), `pin_irq` equals enable AND (source XOR polarity) one cycle later, where polarity 1 means active low. It drops as soon as the level goes inactive.
- R7: For a pin with sensitivity 1 (address 6) and edge mode 0 (address 7), a source transition into the active level sets the pin's pending bit. A transition out of the active level does not set it.
- R8: For a pin with sensitivity 1 and edge mode 1, every source transition sets the pending bit, whatever the polarity.
- R9: Pending bits stay set until a write of 1 to address 8. A detected edge in the same cycle as the clear leaves the bit set. An edge-mode pin's `pin_irq` equals enable AND pending one cycle later.
- R10: An output pin uses its driven value as the interrupt source, so writes to addresses 1, 2 and 9 raise level and edge requests exactly as input changes do.
- R11: `irq_any` is the OR of all bits of `pin_irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Registered read data |
| pins_in | input | NPIN | Asynchronous pin levels from the pads |
| pin_out | output | NPIN | Output latch to the pads |
| pin_oe | output | NPIN | Pad output enables (direction) |
| pin_irq | output | NPIN | Per-pin interrupt requests |
| irq_any | output | 1 | OR of the per-pin requests |

## Verification
The assertions assume that no write happens while reset is high, so the first cycle after reset compares against values set by reset. They also treat `wdata` as meaningful only when `wr_en` is high. The stimulus drives every strobe and data input on the falling clock edge and releases reset with the bus idle. It changes `pins_in` only between edges, so the two synchronizer stages give a known latency. Pin toggles are placed both alone and in the same cycle as a pending clear, which exercises the rule that a new event beats the clear.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 4'd0,
    A_DSET = 4'd1,
    A_DCLR = 4'd2,
    A_MSET = 4'd3,
    A_MCLR = 4'd4,
    A_POL  = 4'd5,
    A_SENS = 4'd6,
    A_BOTH = 4'd7,
    A_PEND = 4'd8,
    A_DATA = 4'd9
  } flag_addr_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/flag_regs.sv
module flag_regs
  import flag_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   src,
  input  logic [NPIN-1:0]   pend,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   out_q,
  output logic [NPIN-1:0]   mask_q,
  output logic [NPIN-1:0]   pol_q,
  output logic [NPIN-1:0]   sens_q,
  output logic [NPIN-1:0]   both_q,
  output logic [NPIN-1:0]   pend_clr,
  output logic [NPIN-1:0]   rdata
);
  logic [NPIN-1:0] rd_mux;

  always_comb begin
    pend_clr = '0;
    if (wr_en && addr == A_PEND) pend_clr = wdata;
  end

  always_comb begin
    case (addr)
      A_DIR:          rd_mux = dir_q;
      A_DSET, A_DCLR: rd_mux = src;
      A_MSET, A_MCLR: rd_mux = mask_q;
      A_POL:          rd_mux = pol_q;
      A_SENS:         rd_mux = sens_q;
      A_BOTH:         rd_mux = both_q;
      A_PEND:         rd_mux = pend;
      A_DATA:         rd_mux = out_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      sens_q <= '0;
      both_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q  <= wdata;
          A_DSET:  out_q  <= out_q | wdata;
          A_DCLR:  out_q  <= out_q & ~wdata;
          A_DATA:  out_q  <= wdata;
          A_MSET:  mask_q <= mask_q | wdata;
          A_MCLR:  mask_q <= mask_q & ~wdata;
          A_POL:   pol_q  <= wdata;
          A_SENS:  sens_q <= wdata;
          A_BOTH:  both_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flag_detect.sv
module flag_detect #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] src,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] sens,
  input  logic [NPIN-1:0] both,
  input  logic [NPIN-1:0] mask,
  input  logic [NPIN-1:0] pend_clr,
  output logic [NPIN-1:0] pend,
  output logic [NPIN-1:0] pin_irq,
  output logic            irq_any
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] req;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic active;
    logic event_hit;

    assign active    = src[i] ^ pol[i];
    assign event_hit = sens[i] && (src[i] != prev_q[i]) && (both[i] || active);
    assign req[i]    = mask[i] && (sens[i] ? pend[i] : active);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i]  <= 1'b0;
        pend[i]    <= 1'b0;
        pin_irq[i] <= 1'b0;
      end else begin
        prev_q[i]  <= src[i];
        pend[i]    <= (pend[i] && !pend_clr[i]) || event_hit;
        pin_irq[i] <= req[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_any <= 1'b0;
    else     irq_any <= |req;
  end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  input  logic [NPIN-1:0]   pins_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_irq,
  output logic              irq_any
);
  logic [NPIN-1:0] sync_q, src;
  logic [NPIN-1:0] dir_q, out_q, mask_q, pol_q, sens_q, both_q;
  logic [NPIN-1:0] pend_q, pend_clr;

  flag_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(sync_q)
  );

  assign src = (dir_q & out_q) | (~dir_q & sync_q);

  flag_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .src(src), .pend(pend_q),
    .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q), .pol_q(pol_q),
    .sens_q(sens_q), .both_q(both_q), .pend_clr(pend_clr), .rdata(rdata)
  );

  flag_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst(rst), .src(src), .pol(pol_q), .sens(sens_q),
    .both(both_q), .mask(mask_q), .pend_clr(pend_clr), .pend(pend_q),
    .pin_irq(pin_irq), .irq_any(irq_any)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/flag_ctrl_chk.sv
module flag_ctrl_chk
  import flag_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPIN-1:0]   wdata,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_irq,
  input logic              irq_any,
  input logic [NPIN-1:0]   mask_q
);
  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIR) |=> (pin_oe == $past(wdata)));

  p_dir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_DIR) |=> $stable(pin_oe));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DSET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DCLR) |=> ((pin_out & $past(wdata)) == '0));

  p_keep_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_DSET || addr == A_DCLR)) |=>
      ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_irq & ~$past(mask_q)) == '0));

  p_any_or_r11: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|pin_irq));
endmodule

bind flag_ctrl flag_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .pin_irq(pin_irq),
  .irq_any(irq_any), .mask_q(mask_q)
);

// File: tb/tb_flag_ctrl.sv
module tb_flag_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0, pins_in = '0;
  logic [N-1:0] rdata, pin_out, pin_oe, pin_irq;
  logic         irq_any;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  flag_ctrl #(.NPIN(N)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_irq(pin_irq), .irq_any(irq_any)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  bit [N-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_mask, m_pol, m_sens, m_both;
  bit [N-1:0] m_pend, m_irq, m_rdata;
  bit         m_any;

  always @(posedge clk) begin
    bit [N-1:0] src, clr, nirq, ev;
    bit any;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_out = 0; m_mask = 0;
      m_pol = 0; m_sens = 0; m_both = 0; m_pend = 0; m_irq = 0; m_rdata = 0;
      m_any = 0;
    end else begin
      any = 0;
      clr = (wr_en && addr == 4'd8) ? wdata : '0;
      for (int i = 0; i < N; i++) begin
        bit act;
        src[i] = m_dir[i] ? m_out[i] : m_s2[i];
        act = src[i] ^ m_pol[i];
        ev[i] = m_sens[i] && (src[i] != m_prev[i]) && (m_both[i] || act);
        nirq[i] = m_mask[i] && (m_sens[i] ? m_pend[i] : act);
        if (nirq[i]) any = 1;
      end
      if (rd_en) begin
        case (addr)
          4'd0: m_rdata = m_dir;
          4'd1, 4'd2: m_rdata = src;
          4'd3, 4'd4: m_rdata = m_mask;
          4'd5: m_rdata = m_pol;
          4'd6: m_rdata = m_sens;
          4'd7: m_rdata = m_both;
          4'd8: m_rdata = m_pend;
          4'd9: m_rdata = m_out;
          default: m_rdata = 0;
        endcase
      end
      m_pend = (m_pend & ~clr) | ev;
      m_irq = nirq;
      m_any = any;
      if (wr_en) begin
        case (addr)
          4'd0: m_dir = wdata;
          4'd1: m_out = m_out | wdata;
          4'd2: m_out = m_out & ~wdata;
          4'd9: m_out = wdata;
          4'd3: m_mask = m_mask | wdata;
          4'd4: m_mask = m_mask & ~wdata;
          4'd5: m_pol = wdata;
          4'd6: m_sens = wdata;
          4'd7: m_both = wdata;
          default: ;
        endcase
      end
      m_prev = src;
      m_s2 = m_s1;
      m_s1 = pins_in;
    end
  end

  task automatic chk(input string req, input string nm, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R2", "pin_oe", pin_oe, m_dir);
    chk("R3", "pin_out", pin_out, m_out);
    chk(cur_req, "rdata", rdata, m_rdata);
    chk(cur_req, "pin_irq", pin_irq, m_irq);
    chk("R11", "irq_any", {{(N-1){1'b0}}, irq_any}, {{(N-1){1'b0}}, m_any});
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk); pins_in = v;
  endtask

  initial begin
    // R1: reset values, checked on every cycle during and after reset
    cur_req = "R1";
    pins_in = 8'h5A;
    idle(4);
    @(negedge clk); rst = 0;
    idle(2);
    for (int a = 0; a < 10; a++) rd(a[3:0]);

    cur_req = "R2";
    wr(4'd0, 8'hF0);
    idle(2);
    rd(4'd0);

    cur_req = "R3";
    wr(4'd1, 8'h30);
    wr(4'd2, 8'h10);
    wr(4'd1, 8'h00);
    wr(4'd9, 8'hA5);
    wr(4'd2, 8'h0F);
    rd(4'd9);

    cur_req = "R4";
    pins(8'h0C); idle(3); rd(4'd1);
    pins(8'h03); rd(4'd2); rd(4'd2); rd(4'd2);
    rd(4'd12); rd(4'd15);

    cur_req = "R5";
    wr(4'd3, 8'hFF);
    wr(4'd4, 8'h0F);
    rd(4'd3);
    wr(4'd4, 8'hF0);
    rd(4'd4);

    cur_req = "R6";
    wr(4'd3, 8'h0F);
    wr(4'd5, 8'h0C);
    pins(8'h05); idle(3);
    pins(8'h0A); idle(3);
    pins(8'h00); idle(3);

    cur_req = "R7";
    wr(4'd6, 8'h0F);
    wr(4'd7, 8'h00);
    wr(4'd8, 8'hFF);
    pins(8'h0F); idle(4); rd(4'd8);
    wr(4'd8, 8'hFF);
    pins(8'h00); idle(4); rd(4'd8);

    cur_req = "R8";
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'h03);
    pins(8'h03); idle(4); rd(4'd8);
    wr(4'd8, 8'h03);
    pins(8'h00); idle(4); rd(4'd8);

    cur_req = "R9";
    wr(4'd8, 8'h01); rd(4'd8);
    pins(8'h02); idle(1);
    wr(4'd8, 8'h02);
    rd(4'd8);
    wr(4'd8, 8'hFF); rd(4'd8);

    cur_req = "R10";
    wr(4'd3, 8'hF0);
    wr(4'd6, 8'hCF);
    wr(4'd7, 8'h43);
    wr(4'd5, 8'h20);
    wr(4'd9, 8'h00);
    wr(4'd8, 8'hFF);
    wr(4'd1, 8'hC0); idle(3); rd(4'd8);
    wr(4'd2, 8'h40); idle(3); rd(4'd8);
    wr(4'd1, 8'h30); idle(3);
    wr(4'd8, 8'hFF); idle(3);

    cur_req = "R11";
    wr(4'd2, 8'hFF); wr(4'd4, 8'hFF); idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule